// File: doc/BRIEF.md
# Half and Single Precision Float Converter

This block converts floating-point values between the IEEE 754 binary16 (half) and binary32 (single) encodings using only integer datapath logic. A direction input selects the conversion for each operation. Widening from half to single is always exact. Narrowing from single to half rounds under a 2-bit rounding-mode input. A separate truncate request forces round-toward-zero whatever the mode says. The mode is meant to be wired from a status field whose reset value is round-to-nearest-even.

Both conversions sort their input into zero, subnormal, normal, infinity and NaN before producing a result. Every NaN leaves the block as one fixed quiet NaN pattern, so the input's sign and payload are discarded. The result is registered. A half-precision result appears zero-extended in the low 16 bits of the 32-bit output word.

Top module: `fp_half_single_cvt`

## Requirements
- R1: When `in_dir` is 0 the block widens the half value in `in_operand[15:0]`. A normal half with exponent field e and fraction m gives a single with the same sign, exponent field e+112 and fraction m followed by 13 zero bits.
- R2: When widening, a subnormal half (exponent field 0, fraction m nonzero) is normalised into an exact normal single. For example 0x0001 gives 0x33800000 and 0x03FF gives 0x387FC000.
- R3: When widening, a signed zero gives a single zero of the same sign, and a half infinity gives a single infinity of the same sign.
- R4: Any NaN input gives the canonical quiet NaN: 0x7FC00000 when widening and 0x00007E00 when narrowing, whatever the sign and payload.
- R5: When `in_dir` is 1 and the rounding mode is 0 (nearest-even), the single in `in_operand` is rounded to the nearest half, and ties go to the even fraction. For example 0x3F801000 gives 0x3C00 and 0x3F803000 gives 0x3C02.
- R6: Rounding-mode encoding: 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. Each directed mode rounds an inexact result in its own direction, and the sign of the input is taken into account.
- R7: When `in_trunc` is 1, narrowing rounds toward zero whatever the value of `in_rmode`.
- R8: When narrowing, a finite value beyond the half range gives infinity in nearest-even, and the largest finite half (magnitude 0x7BFF) in toward-zero. In the directed modes it gives infinity only when the rounding direction points away from zero. A round-up from 0x7BFF gives infinity.
- R9: When narrowing, a value below the half normal range gives a correctly rounded half subnormal or a signed zero. A round-up out of the largest subnormal gives the smallest normal (0x0400).
- R10: A narrowing result has bits [31:16] of `out_result` equal to zero.
- R11: `out_valid` is `in_valid` delayed by one clock. `out_result` takes the new result on the clock after `in_valid` is high, and holds its value while `in_valid` is low.
- R12: Synchronous active-high reset clears `out_valid` and `out_result` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| in_dir | input | 1 | 0 = half to single, 1 = single to half |
| in_rmode | input | 2 | Rounding mode for narrowing (see R6) |
| in_trunc | input | 1 | Force round-toward-zero when narrowing |
| in_operand | input | 32 | Source value (half uses bits [15:0]) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 32 | Converted value (half zero-extended) |

## Verification
The clocked properties assume that `in_valid` stays low while reset is asserted. They also assume that direction, mode, truncate and operand are fully known in every cycle where `in_valid` is high. Without the first assumption, the one-cycle-latency and hold properties could see a request that reset discarded. The stimulus changes inputs only on the falling clock edge, keeps `in_valid` low through the reset window, and sets every input field on every operation, including the random ones. Idle cycles are mixed in so that the hold behaviour is observed between requests.

// File: rtl/fpcvt_pkg.sv
`timescale 1ns/1ps
package fpcvt_pkg;
  localparam int H_EXP = 5;
  localparam int H_MAN = 10;
  localparam int S_EXP = 8;
  localparam int S_MAN = 23;
  localparam int H_BIAS = (1 << (H_EXP - 1)) - 1;
  localparam int S_BIAS = (1 << (S_EXP - 1)) - 1;
  localparam int BIAS_GAP = S_BIAS - H_BIAS;
  localparam int DEN_BASE = BIAS_GAP - H_MAN + 1;
  localparam int NRW_SHIFT = S_MAN - H_MAN;
  localparam int NRW_SHMAX = S_MAN + 3;
  localparam logic [31:0] S_QNAN = 32'h7FC0_0000;
  localparam logic [15:0] H_QNAN = 16'h7E00;
  localparam logic [H_EXP+H_MAN-1:0] H_INF_MAG = 15'h7C00;
  localparam logic [H_EXP+H_MAN-1:0] H_MAX_MAG = 15'h7BFF;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;
endpackage

// File: rtl/fpcvt_widen.sv
`timescale 1ns/1ps
module fpcvt_widen
  import fpcvt_pkg::*;
(
  input  logic [15:0] h_in,
  output logic [31:0] f_out
);
  logic             sgn;
  logic [H_EXP-1:0] ex;
  logic [H_MAN-1:0] mn;
  assign {sgn, ex, mn} = h_in;

  // leading-one position of a subnormal fraction
  logic [3:0]     lead;
  logic [H_MAN:0] nrm;
  logic [7:0]     den_exp;

  always_comb begin
    lead = 4'd0;
    for (int i = 0; i < H_MAN; i++) begin
      if (mn[i]) lead = 4'(i);
    end
  end

  assign nrm     = {1'b0, mn} << (4'(H_MAN) - lead);
  assign den_exp = 8'(lead) + 8'(DEN_BASE);

  always_comb begin
    if (ex == '1) begin
      f_out = (mn != '0) ? S_QNAN : {sgn, 8'hFF, 23'd0};
    end else if (ex == '0) begin
      if (mn == '0) f_out = {sgn, 31'd0};
      else          f_out = {sgn, den_exp, nrm[H_MAN-1:0], 13'd0};
    end else begin
      f_out = {sgn, 8'(ex) + 8'(BIAS_GAP), mn, 13'd0};
    end
  end
endmodule

// File: rtl/fpcvt_narrow.sv
`timescale 1ns/1ps
module fpcvt_narrow
  import fpcvt_pkg::*;
(
  input  logic [31:0] f_in,
  input  logic [1:0]  rmode,
  input  logic        trunc,
  output logic [31:0] h_out
);
  localparam int MAGW = H_EXP + H_MAN;
  localparam int EXTW = S_MAN + 1 + NRW_SHMAX;
  localparam int KEPW = H_MAN + 1;
  localparam int SHDW = KEPW + NRW_SHMAX;

  logic             sgn;
  logic [S_EXP-1:0] ex;
  logic [S_MAN-1:0] mn;
  assign {sgn, ex, mn} = f_in;

  logic is_nan, is_inf;
  assign is_inf = (ex == '1) && (mn == '0);
  assign is_nan = (ex == '1) && (mn != '0);

  rmode_e mode;
  assign mode = trunc ? RM_ZERO : rmode_e'(rmode);

  // target half exponent, signed; subnormal singles act as exponent 1
  logic signed [9:0] eh;
  assign eh = $signed({2'b00, (ex == '0) ? 8'd1 : ex}) - 10'sd112;

  logic [4:0] sh;
  always_comb begin
    if (eh >= 10'sd1)        sh = 5'(NRW_SHIFT);
    else if (eh <= -10'sd12) sh = 5'(NRW_SHMAX);
    else                     sh = 5'(10'sd14 - eh);
  end

  logic [EXTW-1:0] ext;
  logic [SHDW-1:0] shd;
  logic [KEPW-1:0] kept;
  logic            rnd, stk, inexact;
  assign ext     = {(ex != '0), mn, {NRW_SHMAX{1'b0}}};
  assign shd     = SHDW'(ext >> sh);
  assign kept    = shd[SHDW-1:NRW_SHMAX];
  assign rnd     = shd[NRW_SHMAX-1];
  assign stk     = |shd[NRW_SHMAX-2:0];
  assign inexact = rnd | stk;

  logic up;
  always_comb begin
    case (mode)
      RM_NEAR: up = rnd & (stk | kept[0]);
      RM_ZERO: up = 1'b0;
      RM_UP:   up = inexact & ~sgn;
      default: up = inexact & sgn;
    endcase
  end

  // the increment carries into the exponent field on its own
  logic [MAGW-1:0] base, mag;
  assign base = (eh >= 10'sd1) ? ({eh[4:0] - 5'd1, {H_MAN{1'b0}}} + MAGW'(kept))
                               : MAGW'(kept);
  assign mag  = base + MAGW'(up);

  logic            ovf, ovf_inf;
  logic [MAGW-1:0] ovf_mag;
  assign ovf     = eh >= 10'sd31;
  assign ovf_inf = (mode == RM_NEAR) || (mode == RM_UP && !sgn) || (mode == RM_DOWN && sgn);
  assign ovf_mag = ovf_inf ? H_INF_MAG : H_MAX_MAG;

  always_comb begin
    if (is_nan)      h_out = {16'd0, H_QNAN};
    else if (is_inf) h_out = {16'd0, sgn, H_INF_MAG};
    else if (ovf)    h_out = {16'd0, sgn, ovf_mag};
    else             h_out = {16'd0, sgn, mag};
  end
endmodule

// File: rtl/fp_half_single_cvt.sv
`timescale 1ns/1ps
module fp_half_single_cvt
  import fpcvt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_dir,
  input  logic [1:0]  in_rmode,
  input  logic        in_trunc,
  input  logic [31:0] in_operand,
  output logic        out_valid,
  output logic [31:0] out_result
);
  logic [31:0] w_res, n_res, sel_res;

  fpcvt_widen u_widen (
    .h_in  (in_operand[15:0]),
    .f_out (w_res)
  );

  fpcvt_narrow u_narrow (
    .f_in  (in_operand),
    .rmode (in_rmode),
    .trunc (in_trunc),
    .h_out (n_res)
  );

  assign sel_res = in_dir ? n_res : w_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= sel_res;
    end
  end

  // latency and hold
  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result)));

  // NaN canonicalisation on both paths
  assert_wide_nan_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_dir && in_operand[14:10] == 5'h1F && in_operand[9:0] != '0)
      |=> out_result == S_QNAN);
  assert_narrow_nan_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_dir && in_operand[30:23] == 8'hFF && in_operand[22:0] != '0)
      |=> out_result == {16'd0, H_QNAN});

  // narrowing result is zero-extended
  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_dir) |=> out_result[31:16] == 16'd0);

  // toward-zero never creates an infinity from a finite input
  assert_rtz_finite_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_dir && (in_trunc || in_rmode == 2'd1) && in_operand[30:23] != 8'hFF)
      |=> out_result[14:10] != 5'h1F);

  // widening keeps the sign of every non-NaN value
  assert_sign_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_dir && !(in_operand[14:10] == 5'h1F && in_operand[9:0] != '0))
      |=> out_result[31] == $past(in_operand[15]));
endmodule

// File: tb/sim_fp_half_single_cvt.sv
`timescale 1ns/1ps
module sim_fp_half_single_cvt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_dir = 1'b0;
  logic [1:0]  in_rmode = 2'd0;
  logic        in_trunc = 1'b0;
  logic [31:0] in_operand = 32'd0;
  logic        out_valid;
  logic [31:0] out_result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_half_single_cvt u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dir(in_dir),
    .in_rmode(in_rmode), .in_trunc(in_trunc), .in_operand(in_operand),
    .out_valid(out_valid), .out_result(out_result)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [31:0] ref_widen(input logic [15:0] h);
    logic s; int e; int m; int ex;
    s = h[15]; e = int'(h[14:10]); m = int'(h[9:0]);
    if (e == 31) return (m != 0) ? 32'h7FC00000 : {s, 8'hFF, 23'd0};
    if (e == 0 && m == 0) return {s, 31'd0};
    if (e == 0) begin
      ex = 113;
      while (m < 1024) begin m = m * 2; ex = ex - 1; end
      return {s, 8'(ex), 10'(m - 1024), 13'd0};
    end
    return {s, 8'(e + 112), 10'(m), 13'd0};
  endfunction

  // half magnitude code -> value in units of 2^-50
  function automatic logic [127:0] hval(input int code);
    int e; int m; logic [127:0] u;
    e = code / 1024; m = code % 1024;
    if (e == 0) u = 128'(m);
    else        u = 128'(1024 + m) << (e - 1);
    return u << 26;
  endfunction

  function automatic logic [31:0] ref_narrow(input logic [31:0] f, input int rm, input bit tr);
    logic s; int e; int m; int mode; int h; int res;
    logic [127:0] x, lo, hi;
    bit away;
    s = f[31]; e = int'(f[30:23]); m = int'(f[22:0]);
    mode = tr ? 1 : rm;
    away = (mode == 2 && !s) || (mode == 3 && s);
    if (e == 255) return (m != 0) ? 32'h00007E00 : {16'd0, s, 15'h7C00};
    if (e == 0 && m == 0) return {16'd0, s, 15'd0};
    if (e >= 143) begin
      if (mode == 0 || away) res = 31744; else res = 31743;
      return {16'd0, s, 15'(res)};
    end
    if (e < 100) return {16'd0, s, 15'(away ? 1 : 0)};
    x = 128'(m + 8388608) << (e - 100);
    h = 0;
    for (int b = 14; b >= 0; b--) begin
      if ((h | (1 << b)) <= 31743 && hval(h | (1 << b)) <= x) h = h | (1 << b);
    end
    lo = hval(h); hi = hval(h + 1);
    res = h;
    if (x != lo) begin
      case (mode)
        0: begin
          if (2 * x > lo + hi) res = h + 1;
          else if (2 * x == lo + hi) res = (h % 2 == 1) ? h + 1 : h;
        end
        1: res = h;
        default: res = away ? h + 1 : h;
      endcase
    end
    return {16'd0, s, 15'(res)};
  endfunction

  function automatic string tag_of(input bit dir, input logic [31:0] f, input int rm, input bit tr);
    if (!dir) begin
      if (f[14:10] == 5'h1F && f[9:0] != 0) return "R4";
      if (f[14:10] == 5'h1F || f[14:0] == 0) return "R3";
      if (f[14:10] == 0) return "R2";
      return "R1";
    end
    if (f[30:23] == 8'hFF && f[22:0] != 0) return "R4";
    if (tr) return "R7";
    if (f[30:23] >= 8'd142) return "R8";
    if (f[30:23] < 8'd113) return "R9";
    if (rm != 0) return "R6";
    return "R5";
  endfunction

  // cycle model: what the outputs must show after each edge
  logic        exp_v = 1'b0;
  logic [31:0] exp_r = 32'd0;
  logic        exp_narrow = 1'b0;
  string       exp_tag = "R12";

  always @(posedge clk) begin
    if (rst) begin
      exp_v <= 1'b0; exp_r <= 32'd0; exp_narrow <= 1'b0; exp_tag <= "R12";
    end else begin
      exp_v <= in_valid;
      exp_narrow <= in_valid && in_dir;
      if (in_valid) begin
        exp_r <= in_dir ? ref_narrow(in_operand, int'(in_rmode), in_trunc)
                        : ref_widen(in_operand[15:0]);
        exp_tag <= tag_of(in_dir, in_operand, int'(in_rmode), in_trunc);
      end else begin
        exp_tag <= "R11";
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== exp_v) begin
        fails++;
        $display("FAIL %s/R11 out_valid actual=%b expected=%b", exp_tag, out_valid, exp_v);
      end
      checks++;
      if (out_result !== exp_r) begin
        fails++;
        $display("FAIL %s out_result actual=%h expected=%h", exp_tag, out_result, exp_r);
      end
      if (exp_v && exp_narrow) begin
        checks++; // R10 zero extension
        if (out_result[31:16] !== 16'd0) begin
          fails++;
          $display("FAIL R10 upper half actual=%h expected=0000", out_result[31:16]);
        end
      end
    end
  end

  task automatic op(input bit dir, input logic [1:0] rm, input bit tr, input logic [31:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_dir = dir; in_rmode = rm; in_trunc = tr; in_operand = v;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_dir = 1'b0; in_rmode = 2'd0; in_trunc = 1'b0;
    in_operand = 32'hDEAD_BEEF;
  endtask

  task automatic all_modes(input logic [31:0] v);
    for (int r = 0; r < 4; r++) op(1'b1, 2'(r), 1'b0, v);
  endtask

  initial begin
    repeat (4) @(negedge clk); // R12 reset state checked each cycle
    rst = 1'b0;
    idle();
    // R1 normals
    op(0, 0, 0, 32'h3C00); op(0, 0, 0, 32'h7BFF); op(0, 0, 0, 32'hC400); op(0, 0, 0, 32'h0400);
    // R2 subnormals
    op(0, 0, 0, 32'h0001); op(0, 0, 0, 32'h03FF); op(0, 0, 0, 32'h8200);
    // R3 zeros and infinities
    op(0, 0, 0, 32'h0000); op(0, 0, 0, 32'h8000); op(0, 0, 0, 32'h7C00); op(0, 0, 0, 32'hFC00);
    // R4 NaNs, both paths
    op(0, 0, 0, 32'h7C01); op(0, 0, 0, 32'hFE00); op(0, 0, 0, 32'hFFFF_7D55);
    op(1, 0, 0, 32'h7F800001); op(1, 2, 0, 32'hFFC00000); op(1, 1, 1, 32'h7FFFFFFF);
    idle(); idle(); // R11 hold
    // R5 nearest-even ties and non-ties
    op(1, 0, 0, 32'h3F800000); op(1, 0, 0, 32'h3F801000); op(1, 0, 0, 32'h3F803000);
    op(1, 0, 0, 32'h3F801001); op(1, 0, 0, 32'hBF803000);
    // R6 directed modes, both signs
    all_modes(32'h3F800001); all_modes(32'hBF800001); all_modes(32'h40490FDB);
    // R7 truncate overrides every mode
    for (int r = 0; r < 4; r++) begin
      op(1, 2'(r), 1, 32'h3F801FFF); op(1, 2'(r), 1, 32'hC7800000); op(1, 2'(r), 1, 32'h00000001);
    end
    // R8 overflow
    all_modes(32'h47800000); all_modes(32'hC7800000); all_modes(32'h477FF000);
    all_modes(32'h477FEFFF); all_modes(32'h7F7FFFFF); all_modes(32'h7F800000);
    // R9 tiny values and carry into min normal
    all_modes(32'h33800000); all_modes(32'h33000000); all_modes(32'h33000001);
    all_modes(32'h387FF000); all_modes(32'h00000001); all_modes(32'h80000001);
    all_modes(32'h35000000); all_modes(32'hB4C00000);
    idle();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k; logic [31:0] v;
      k = int'($urandom_range(0, 9));
      if (k == 0) idle();
      else if (k < 4) op(0, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom);
      else begin
        v = $urandom;
        if (k < 8) v[30:23] = 8'($urandom_range(95, 148));
        op(1, 2'($urandom_range(0, 3)), ($urandom_range(0, 5) == 0), v);
      end
    end
    idle(); idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule